// File: doc/BRIEF.md
# NOR Flash Array Program/Erase Emulator

This block models, at reduced scale, the storage array of a word-wide NOR flash memory. A client issues one request at a time: a read, a word program, a sector erase or a full-array erase. Each request carries a word address and a 16-bit data value. The array lives in internal registers. Its total size and its sector size are parameters.

The block keeps the physical rules of such an array. An erased cell holds 1, and the array comes out of reset fully erased. A program operation can only turn ones into zeros, because the stored word becomes the old word ANDed with the written data. The only way to turn a bit back to 1 is to erase the aligned sector that holds it, or the whole array.

Program and erase run for many cycles with `busy` high. An erase clears one word per clock, so its duration grows with the amount of storage it covers. Any request presented while `busy` is high is refused and has no effect.

Top module: `nor_array_emu`

## Requirements
- R1: After reset, `busy` and `rd_valid` are 0, and every word reads back as 16'hFFFF.
- R2: When `req_accept` is high at a clock edge with `req_op` = 2'd0 (read), `rd_valid` is high for exactly the following cycle, and `rd_data` then holds the word at `req_addr`.
- R3: A program request (`req_op` = 2'd1) leaves the addressed word equal to its previous value ANDed with `req_wdata`, so a programmed bit never goes from 0 to 1.
- R4: After an accepted program, `busy` is high for exactly PROG_CYCLES cycles, and a read accepted after `busy` falls returns the new value.
- R5: A sector erase (`req_op` = 2'd2) sets every word of the aligned block of SECTOR_WORDS words that contains `req_addr` to 16'hFFFF, and leaves all other words unchanged.
- R6: For a sector erase, the low log2(SECTOR_WORDS) bits of `req_addr` are ignored, so any address inside a sector erases that same whole sector.
- R7: After an accepted sector erase, `busy` is high for exactly SECTOR_WORDS cycles.
- R8: A chip erase (`req_op` = 2'd3) sets every word to 16'hFFFF, with `busy` high for exactly WORDS cycles.
- R9: While `busy` is high, `req_accept` is 0. A request presented then does not change the array and produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | log2(WORDS) | Word address |
| req_wdata | input | 16 | Program data |
| req_accept | output | 1 | Request taken this cycle |
| busy | output | 1 | Program or erase in progress |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |

## Verification
The bench programs the same word twice with overlapping zero patterns. A design that overwrote the word instead of ANDing into it would bring cleared bits back to 1.

It erases sectors through an address in the middle of the sector and checks the words on both sides of the sector boundary. A design that did not align the address would clear the wrong words, and one with an off-by-one erase loop would miss the last word or touch a word in the next sector.

It measures the number of busy cycles for program, sector erase and chip erase. It also presents program and read requests during an erase. A design that accepted those requests would corrupt the array or produce a stray read response.

// File: rtl/nor_array_emu.sv
module nor_array_emu #(
  parameter int WORDS        = 256,
  parameter int SECTOR_WORDS = 32,
  parameter int PROG_CYCLES  = 4,
  parameter int DW           = 16,
  localparam int AW = $clog2(WORDS),
  localparam int CW = $clog2(WORDS + PROG_CYCLES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_accept,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_PROG = 2'd1;
  localparam logic [1:0] OP_SECT = 2'd2;
  localparam logic [1:0] OP_CHIP = 2'd3;
  localparam logic [AW-1:0] SECT_MASK = ~AW'(SECTOR_WORDS - 1);

  logic [DW-1:0] mem [WORDS];
  logic          erasing;
  logic [AW-1:0] ptr;
  logic [CW-1:0] cnt;
  logic [DW-1:0] wdat;

  assign req_accept = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      busy     <= 1'b0;
      erasing  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '1;
      ptr      <= '0;
      cnt      <= '0;
      wdat     <= '1;
    end else begin
      rd_valid <= 1'b0;
      if (req_accept) begin
        case (req_op)
          OP_READ: begin
            rd_valid <= 1'b1;
            rd_data  <= mem[req_addr];
          end
          OP_PROG: begin
            busy    <= 1'b1;
            erasing <= 1'b0;
            ptr     <= req_addr;
            wdat    <= req_wdata;
            cnt     <= CW'(PROG_CYCLES - 1);
          end
          OP_SECT: begin
            busy    <= 1'b1;
            erasing <= 1'b1;
            ptr     <= req_addr & SECT_MASK;
            cnt     <= CW'(SECTOR_WORDS - 1);
          end
          default: begin
            busy    <= 1'b1;
            erasing <= 1'b1;
            ptr     <= '0;
            cnt     <= CW'(WORDS - 1);
          end
        endcase
      end else if (busy) begin
        if (erasing) begin
          mem[ptr] <= '1;
          ptr      <= ptr + 1'b1;
        end
        if (cnt == '0) begin
          busy <= 1'b0;
          if (!erasing) mem[ptr] <= mem[ptr] & wdat;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R9: a refused request must not start anything
  p_refuse_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(cnt == '0) |=> busy && !rd_valid);

  // R2
  p_rd_valid_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !busy && req_op == OP_READ));

  // R3
  p_prog_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !erasing && cnt == '0 |=>
      ((mem[$past(ptr)] & ~$past(mem[ptr])) == '0) &&
      ((mem[$past(ptr)] & ~$past(wdat)) == '0));

  // R5, R8
  p_erase_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && erasing |=> mem[$past(ptr)] == '1);

  // R4, R7, R8
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept && req_op != OP_READ |=> busy);
endmodule

// File: tb/nor_array_emu_tb.sv
module nor_array_emu_tb;
  localparam int WORDS = 64;
  localparam int SECTOR_WORDS = 16;
  localparam int PROG_CYCLES = 3;
  localparam int AW = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_accept, busy, rd_valid;
  logic [15:0] rd_data;
  int checks = 0;
  int failures = 0;
  logic [15:0] model [WORDS];

  always #2.5 clk = ~clk;

  nor_array_emu #(.WORDS(WORDS), .SECTOR_WORDS(SECTOR_WORDS),
                  .PROG_CYCLES(PROG_CYCLES), .DW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_accept(req_accept),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue at a negedge, returns at the next negedge; reports whether it was accepted.
  task automatic issue(input logic [1:0] op, input int addr, input logic [15:0] d,
                       output logic acc);
    req_valid = 1'b1; req_op = op; req_addr = AW'(addr); req_wdata = d;
    #0.1 acc = req_accept;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [15:0] d);
    logic acc;
    issue(2'd0, addr, 16'h0, acc);
    chk("R2 read accepted", 32'(acc), 1);
    chk("R2 rd_valid", 32'(rd_valid), 1);
    d = rd_data;
    @(negedge clk);
    chk("R2 rd_valid one cycle", 32'(rd_valid), 0);
  endtask

  task automatic run_op(input logic [1:0] op, input int addr, input logic [15:0] d,
                        input int exp_len, input string req);
    logic acc;
    int n = 0;
    issue(op, addr, d, acc);
    chk(req, 32'(acc), 1);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(req, n, exp_len);
  endtask

  task automatic check_all(input string req);
    logic [15:0] d;
    int bad = 0;
    for (int i = 0; i < WORDS; i++) begin
      rd(i, d);
      if (d !== model[i]) begin
        bad++;
        chk(req, {16'h0, d}, {16'h0, model[i]});
      end
    end
    chk(req, bad, 0);
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
    check_all("R1 erased");
  endtask

  task automatic t_program;
    logic [15:0] d;
    run_op(2'd1, 5, 16'hF0F0, PROG_CYCLES, "R4 program busy length");
    model[5] = model[5] & 16'hF0F0;
    rd(5, d); chk("R3 program first", d, 16'hF0F0);
    run_op(2'd1, 5, 16'h3C3F, PROG_CYCLES, "R4 program busy length");
    model[5] = model[5] & 16'h3C3F;
    rd(5, d); chk("R3 AND no 0->1", d, 16'h3030);
    run_op(2'd1, 20, 16'h1234, PROG_CYCLES, "R4 program busy length");
    model[20] = 16'h1234;
    run_op(2'd1, 15, 16'h0000, PROG_CYCLES, "R4 program busy length");
    model[15] = 16'h0000;
    run_op(2'd1, 16, 16'hA5A5, PROG_CYCLES, "R4 program busy length");
    model[16] = 16'hA5A5;
    run_op(2'd1, 31, 16'h0F0F, PROG_CYCLES, "R4 program busy length");
    model[31] = 16'h0F0F;
    run_op(2'd1, 32, 16'h00FF, PROG_CYCLES, "R4 program busy length");
    model[32] = 16'h00FF;
    rd(20, d); chk("R4 readback", d, 16'h1234);
  endtask

  task automatic t_sector;
    run_op(2'd2, 16 + 7, 16'h0, SECTOR_WORDS, "R7 sector busy length");
    for (int i = 16; i < 32; i++) model[i] = 16'hFFFF;
    check_all("R5 R6 sector erase aligned");
  endtask

  task automatic t_busy_refuse;
    logic acc;
    int n = 0;
    issue(2'd2, 0, 16'h0, acc);
    chk("R9 erase start", 32'(acc), 1);
    issue(2'd1, 40, 16'h0000, acc);
    chk("R9 program refused", 32'(acc), 0);
    issue(2'd0, 32, 16'h0, acc);
    chk("R9 read refused", 32'(acc), 0);
    chk("R9 no rd_valid", 32'(rd_valid), 0);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    for (int i = 0; i < 16; i++) model[i] = 16'hFFFF;
    check_all("R9 array unchanged");
  endtask

  task automatic t_chip;
    logic [15:0] d;
    run_op(2'd1, 63, 16'h0001, PROG_CYCLES, "R4 program busy length");
    run_op(2'd3, 9, 16'h0, WORDS, "R8 chip busy length");
    for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
    check_all("R8 chip erase");
    rd(32, d); chk("R8 word 32", d, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_sector();
    t_busy_refuse();
    t_chip();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule